// File: doc/BRIEF.md
# SPI Master Frame Shifter

This block moves a single SPI frame between a controller and a peripheral. A command presented with a `start` pulse carries the transmit word, the chip-select line to use, a flag that keeps that line asserted once the frame ends, and an index that picks one of several attribute sets. Each attribute set gives the frame length, the clock idle level, the clock phase and the bit order. The block drives SCK, MOSI and the chip-select lines, samples MISO, and returns the received word with a one-cycle `done` pulse.

Half-period timing comes from outside. A prescaler sends a `tick` strobe, and each tick moves SCK by one edge. Queueing of commands, the register interface and DMA belong to neighbouring blocks.

Top module: `spi_frame_shifter`

## Requirements
- R1: After synchronous reset, `sck` is 0, `busy`, `done` and `rx_data` are 0, and every chip-select line sits at its idle level.
- R2: A frame has exactly L+1 SCK periods, where L is the 4-bit length code of the selected set. Legal codes run from 3 to 15 (4 to 16 bits). SCK changes only on a cycle in which `tick` is high.
- R3: `cmd_attr_sel` = i selects set i. Its length code is `cfg_len_m1[4i+3:4i]`, and its idle level, phase and order are bit i of `cfg_cpol`, `cfg_cpha` and `cfg_lsb_first`.
- R4: With the order bit at 1 the frame sends and receives bit 0 of the word first. With it at 0 the frame starts at bit L and works down to bit 0.
- R5: At `done`, `rx_data[L:0]` holds the word received on MISO and every bit above L is 0. The transmit word is latched when the command is taken, so later changes on `tx_data` do not affect the frame.
- R6: SCK sits at the selected idle level from the cycle after the command is taken until the first tick. It returns to that level after the last edge and holds there while the block is idle.
- R7: With phase 0, each bit is on MOSI before its leading SCK edge and MISO is sampled at that edge. With phase 1, MOSI changes at the leading edge and MISO is sampled at the trailing edge.
- R8: While a frame runs, `cs_n` equals `cs_idle_lvl` XOR `cmd_cs_sel` as taken with the command (one-hot select, six lines).
- R9: If `cmd_keep_cs` was 1, the selected line stays asserted after the frame until the next command. If it was 0, all lines go back to idle in the same cycle that `done` rises. `done_cs_kept` reports the flag during `done`.
- R10: `done` is high for exactly one cycle per frame, and `busy` is 0 in that cycle.
- R11: A `start` while `busy` is 1 is ignored. The running frame's data, chip select and timing are unchanged.
- R12: `cs_idle_lvl` sets the idle level of each chip-select line. A selected line is driven to the opposite level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, taken when not busy |
| tx_data | input | 16 | Word to transmit |
| cmd_keep_cs | input | 1 | Keep chip select asserted after the frame |
| cmd_attr_sel | input | 2 | Attribute set index |
| cmd_cs_sel | input | 6 | One-hot chip-select choice |
| cfg_len_m1 | input | 16 | Four 4-bit length codes (bits minus one) |
| cfg_cpol | input | 4 | Clock idle level per set |
| cfg_cpha | input | 4 | Clock phase per set |
| cfg_lsb_first | input | 4 | Bit order per set |
| cs_idle_lvl | input | 6 | Idle level of each chip-select line |
| tick | input | 1 | Half-period strobe from the prescaler |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 6 | Chip-select lines |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| done_cs_kept | output | 1 | Chip select was kept asserted (valid with done) |
| rx_data | output | 16 | Received word |

## Verification
The bench uses the default parameters: a 16-bit data path, six chip-select lines and four attribute sets. These defaults make every legal length code reachable, together with all four combinations of clock idle level and phase and both bit orders. The tick divisor is varied from 1 to 4 cycles, so edges land both on consecutive clocks and with gaps between them. A peripheral model in the bench follows the SCK edges to drive MISO and capture MOSI. A kept chip select is followed into the next frame, and one test uses a mixed idle mask.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;

    localparam int DW   = 16;
    localparam int LENW = $clog2(DW);
    localparam int CNTW = LENW + 1;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } eng_state_e;

    typedef struct packed {
        logic [LENW-1:0] len_m1;
        logic            cpol;
        logic            cpha;
        logic            lsb_first;
    } frame_attr_t;

    // Word position of the idx-th bit on the wire
    function automatic logic [LENW-1:0] bit_slot(
        input logic [LENW-1:0] idx,
        input logic [LENW-1:0] len_m1,
        input logic            lsb_first
    );
        return lsb_first ? idx : (len_m1 - idx);
    endfunction

endpackage

// File: rtl/spi_attr_select.sv
module spi_attr_select
    import spi_shift_pkg::*;
#(
    parameter int N_ATTR = 4,
    parameter int SELW   = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
) (
    input  logic [N_ATTR*LENW-1:0] len_m1_all,
    input  logic [N_ATTR-1:0]      cpol_all,
    input  logic [N_ATTR-1:0]      cpha_all,
    input  logic [N_ATTR-1:0]      lsb_all,
    input  logic [SELW-1:0]        sel,
    output frame_attr_t            attr
);

    frame_attr_t sets [N_ATTR];

    for (genvar g = 0; g < N_ATTR; g++) begin : g_set
        assign sets[g].len_m1    = len_m1_all[g*LENW +: LENW];
        assign sets[g].cpol      = cpol_all[g];
        assign sets[g].cpha      = cpha_all[g];
        assign sets[g].lsb_first = lsb_all[g];
    end

    assign attr = sets[sel];

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_shift_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  frame_attr_t   attr_in,
    input  logic [DW-1:0] tx_in,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          sck,
    output logic          mosi,
    output logic          fin,
    output logic          done,
    output logic [DW-1:0] rx_word
);

    eng_state_e       st;
    frame_attr_t      cfg;
    logic [DW-1:0]    tx_q;
    logic [CNTW-1:0]  edge_cnt;
    logic [LENW-1:0]  bit_idx;
    logic [CNTW-1:0]  last_edge;
    logic [LENW-1:0]  cur_slot;
    logic [LENW-1:0]  nxt_slot;
    logic             lead;

    assign lead      = ~edge_cnt[0];
    assign last_edge = {cfg.len_m1, 1'b1};
    assign busy      = (st == ST_RUN);
    assign fin       = busy && tick && (edge_cnt == last_edge);

    always_comb begin
        cur_slot = bit_slot(bit_idx, cfg.len_m1, cfg.lsb_first);
        nxt_slot = bit_slot(bit_idx + 1'b1, cfg.len_m1, cfg.lsb_first);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg      <= '0;
            tx_q     <= '0;
            edge_cnt <= '0;
            bit_idx  <= '0;
            sck      <= 1'b0;
            mosi     <= 1'b0;
            rx_word  <= '0;
            done     <= 1'b0;
        end else begin
            done <= fin;
            if (st == ST_IDLE) begin
                if (load) begin
                    st       <= ST_RUN;
                    cfg      <= attr_in;
                    tx_q     <= tx_in;
                    rx_word  <= '0;
                    edge_cnt <= '0;
                    bit_idx  <= '0;
                    sck      <= attr_in.cpol;
                    mosi     <= tx_in[bit_slot('0, attr_in.len_m1, attr_in.lsb_first)];
                end
            end else if (tick) begin
                sck      <= ~sck;
                edge_cnt <= edge_cnt + 1'b1;
                if (lead) begin
                    if (cfg.cpha) mosi <= tx_q[cur_slot];
                    else          rx_word[cur_slot] <= miso;
                end else begin
                    if (cfg.cpha)  rx_word[cur_slot] <= miso;
                    else if (!fin) mosi <= tx_q[nxt_slot];
                    if (!fin) bit_idx <= bit_idx + 1'b1;
                end
                if (fin) st <= ST_IDLE;
            end
        end
    end

    // R6: clock holds its level while idle
    p_idle_sck_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(sck));
    // R2: edges only on a tick
    p_tick_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(sck) && $stable(mosi)));
    // R2: edge counter never passes the frame end
    p_edge_bound_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (edge_cnt <= last_edge));
    // R10: single-cycle completion with busy low
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl #(
    parameter int CS_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            busy,
    input  logic            fin,
    input  logic            keep_in,
    input  logic [CS_W-1:0] cs_vec_in,
    input  logic [CS_W-1:0] cs_idle,
    output logic [CS_W-1:0] cs_n,
    output logic            keep_q
);

    logic [CS_W-1:0] cs_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_act <= '0;
            keep_q <= 1'b0;
        end else if (load) begin
            cs_act <= cs_vec_in;
            keep_q <= keep_in;
        end else if (fin && !keep_q) begin
            cs_act <= '0;
        end
    end

    assign cs_n = cs_idle ^ cs_act;

    // R8, R11: selection frozen through a running frame
    p_cs_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin) |=> $stable(cs_act));
    // R8: command selection taken on load
    p_cs_load_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (cs_act == $past(cs_vec_in)));
    // R9: kept line survives the end of frame
    p_cs_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (fin && keep_q) |=> $stable(cs_act));
    // R9: released line returns to idle
    p_cs_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (fin && !keep_q) |=> (cs_act == '0));

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_shift_pkg::*;
#(
    parameter int CS_W   = 6,
    parameter int N_ATTR = 4,
    parameter int SELW   = (N_ATTR > 1) ? $clog2(N_ATTR) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [DW-1:0]          tx_data,
    input  logic                   cmd_keep_cs,
    input  logic [SELW-1:0]        cmd_attr_sel,
    input  logic [CS_W-1:0]        cmd_cs_sel,
    input  logic [N_ATTR*LENW-1:0] cfg_len_m1,
    input  logic [N_ATTR-1:0]      cfg_cpol,
    input  logic [N_ATTR-1:0]      cfg_cpha,
    input  logic [N_ATTR-1:0]      cfg_lsb_first,
    input  logic [CS_W-1:0]        cs_idle_lvl,
    input  logic                   tick,
    input  logic                   miso,
    output logic                   sck,
    output logic                   mosi,
    output logic [CS_W-1:0]        cs_n,
    output logic                   busy,
    output logic                   done,
    output logic                   done_cs_kept,
    output logic [DW-1:0]          rx_data
);

    frame_attr_t sel_attr;
    logic        accept;
    logic        fin;
    logic        keep_q;

    assign accept       = start && !busy;
    assign done_cs_kept = keep_q;

    spi_attr_select #(.N_ATTR(N_ATTR), .SELW(SELW)) u_attr (
        .len_m1_all (cfg_len_m1),
        .cpol_all   (cfg_cpol),
        .cpha_all   (cfg_cpha),
        .lsb_all    (cfg_lsb_first),
        .sel        (cmd_attr_sel),
        .attr       (sel_attr)
    );

    spi_bit_engine u_eng (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .attr_in (sel_attr),
        .tx_in   (tx_data),
        .tick    (tick),
        .miso    (miso),
        .busy    (busy),
        .sck     (sck),
        .mosi    (mosi),
        .fin     (fin),
        .done    (done),
        .rx_word (rx_data)
    );

    spi_cs_ctrl #(.CS_W(CS_W)) u_cs (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .busy      (busy),
        .fin       (fin),
        .keep_in   (cmd_keep_cs),
        .cs_vec_in (cmd_cs_sel),
        .cs_idle   (cs_idle_lvl),
        .cs_n      (cs_n),
        .keep_q    (keep_q)
    );

    // R11: a start during a frame does not end it early
    p_start_ignore_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !fin) |=> busy);

endmodule

// File: tb/spi_frame_shifter_test.sv
module spi_frame_shifter_test;
    import spi_shift_pkg::*;

    localparam int CS_W = 6;
    localparam int NA   = 4;
    localparam int SW   = 2;

    logic clk = 1'b0;
    logic rst;
    logic start;
    logic [DW-1:0] tx_data;
    logic cmd_keep_cs;
    logic [SW-1:0] cmd_attr_sel;
    logic [CS_W-1:0] cmd_cs_sel;
    logic [NA*LENW-1:0] cfg_len_m1;
    logic [NA-1:0] cfg_cpol, cfg_cpha, cfg_lsb_first;
    logic [CS_W-1:0] cs_idle_lvl;
    logic tick;
    logic miso;
    logic sck, mosi, busy, done, done_cs_kept;
    logic [CS_W-1:0] cs_n;
    logic [DW-1:0] rx_data;

    int n_checks = 0;
    int n_err = 0;
    int tick_div = 1;

    always #4 clk = ~clk;

    spi_frame_shifter uut (
        .clk(clk), .rst(rst), .start(start), .tx_data(tx_data),
        .cmd_keep_cs(cmd_keep_cs), .cmd_attr_sel(cmd_attr_sel), .cmd_cs_sel(cmd_cs_sel),
        .cfg_len_m1(cfg_len_m1), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cs_idle_lvl(cs_idle_lvl), .tick(tick),
        .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .done(done), .done_cs_kept(done_cs_kept), .rx_data(rx_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int slot(input int k, input int len_m1, input bit lsb);
        return lsb ? k : (len_m1 - k);
    endfunction

    function automatic logic [DW-1:0] len_mask(input int len_m1);
        return DW'((32'h1 << (len_m1 + 1)) - 1);
    endfunction

    // Tick strobe: one pulse every tick_div cycles
    initial begin
        int cnt = 0;
        tick = 1'b0;
        forever begin
            @(negedge clk);
            cnt  = (cnt + 1 >= tick_div) ? 0 : cnt + 1;
            tick = (cnt == 0);
        end
    end

    initial begin
        #(8 * 190000);
        n_err++;
        n_checks++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    task automatic set_attr(input int i, input int l, input bit p, input bit h, input bit o);
        cfg_len_m1[i*LENW +: LENW] = LENW'(l);
        cfg_cpol[i] = p;
        cfg_cpha[i] = h;
        cfg_lsb_first[i] = o;
    endtask

    task automatic run_frame(input logic [DW-1:0] txd, input logic [DW-1:0] sdat, input bit keep,
                             input int sel, input logic [CS_W-1:0] vec, input bit poke);
        int l  = int'(cfg_len_m1[sel*LENW +: LENW]);
        bit p  = cfg_cpol[sel];
        bit h  = cfg_cpha[sel];
        bit o  = cfg_lsb_first[sel];
        logic [CS_W-1:0] exp_cs = cs_idle_lvl ^ vec;
        logic [DW-1:0] cap = '0;
        int sk = 0, dk = 0, leads = 0;
        bit cs_bad = 0, seen = 0;
        logic prev;

        @(negedge clk);
        start = 1'b1; tx_data = txd; cmd_keep_cs = keep;
        cmd_attr_sel = SW'(sel); cmd_cs_sel = vec;
        @(negedge clk);
        start = 1'b0;
        tx_data = DW'($urandom);  // R5: latched word must not follow the port
        chk(busy === 1'b1, "R10 busy after start", 32'(busy), 1);
        chk(cs_n === exp_cs, "R8 cs at frame start", 32'(cs_n), 32'(exp_cs));
        chk(sck === p, "R6 sck idle level before first edge", 32'(sck), 32'(p));
        if (!h) begin miso = sdat[slot(0, l, o)]; dk = 1; end
        prev = sck;
        for (int it = 0; it < 4000; it++) begin
            @(negedge clk);
            if (poke && it == 2) begin
                start = 1'b1; tx_data = DW'($urandom); cmd_cs_sel = CS_W'(1 << ($urandom % CS_W));
                cmd_attr_sel = SW'($urandom); cmd_keep_cs = ~keep;
            end
            if (poke && it == 3) start = 1'b0;
            if (sck !== prev) begin
                if (sck !== p) begin
                    leads++;
                    if (!h) begin
                        if (sk <= l) cap[slot(sk, l, o)] = mosi;
                        sk++;
                    end else begin
                        if (dk <= l) miso = sdat[slot(dk, l, o)];
                        dk++;
                    end
                end else begin
                    if (!h) begin
                        if (dk <= l) miso = sdat[slot(dk, l, o)];
                        dk++;
                    end else begin
                        if (sk <= l) cap[slot(sk, l, o)] = mosi;
                        sk++;
                    end
                end
            end
            prev = sck;
            if (busy && cs_n !== exp_cs) cs_bad = 1;
            if (done) begin seen = 1; break; end
        end
        chk(seen, "R10 done seen", 32'(seen), 1);
        chk(cs_bad == 0, "R8 R11 cs stable during frame", 32'(cs_bad), 0);
        chk(leads == l + 1, "R2 R3 sck period count", 32'(leads), 32'(l + 1));
        chk(cap === (txd & len_mask(l)), "R4 R7 R3 mosi word", 32'(cap), 32'(txd & len_mask(l)));
        chk(rx_data === (sdat & len_mask(l)), "R5 R7 R4 rx word", 32'(rx_data), 32'(sdat & len_mask(l)));
        chk(done_cs_kept === keep, "R9 kept flag", 32'(done_cs_kept), 32'(keep));
        chk(busy === 1'b0, "R10 busy low at done", 32'(busy), 0);
        chk(sck === p, "R6 sck idle after frame", 32'(sck), 32'(p));
        chk(cs_n === (keep ? exp_cs : cs_idle_lvl), "R9 cs after frame",
            32'(cs_n), 32'(keep ? exp_cs : cs_idle_lvl));
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", 32'(done), 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        rst = 1'b1; start = 1'b0; tx_data = '0; cmd_keep_cs = 1'b0;
        cmd_attr_sel = '0; cmd_cs_sel = '0; cfg_len_m1 = '0;
        cfg_cpol = '0; cfg_cpha = '0; cfg_lsb_first = '0;
        cs_idle_lvl = '1; miso = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        chk(sck === 1'b0, "R1 reset sck", 32'(sck), 0);
        chk(cs_n === 6'h3F, "R1 R12 reset cs idle", 32'(cs_n), 32'h3F);
        chk(busy === 1'b0 && done === 1'b0, "R1 reset busy/done", 32'({busy, done}), 0);
        chk(rx_data === '0, "R1 reset rx", 32'(rx_data), 0);

        // Directed: each set with a distinct mode mix
        set_attr(0, 7, 0, 0, 0);
        set_attr(1, 15, 1, 1, 1);
        set_attr(2, 3, 0, 1, 0);
        set_attr(3, 11, 1, 0, 1);
        tick_div = 1;
        run_frame(16'hA5C3, 16'h3C5A, 0, 0, 6'b000001, 0);
        run_frame(16'h8001, 16'hF00F, 1, 1, 6'b000100, 0);
        repeat (3) @(negedge clk);
        chk(cs_n === (6'h3F ^ 6'b000100), "R9 kept cs persists while idle", 32'(cs_n), 32'(6'h3F ^ 6'b000100));
        run_frame(16'hFFF9, 16'h0006, 0, 2, 6'b100000, 0);
        tick_div = 3;
        run_frame(16'h0ABC, 16'h0543, 0, 3, 6'b010000, 1);  // R11 start during frame
        run_frame(16'hFFFF, 16'h0000, 0, 1, 6'b000010, 0);

        // R12: mixed idle levels
        cs_idle_lvl = 6'b101010;
        @(negedge clk);
        chk(cs_n === 6'b101010, "R12 idle mask on lines", 32'(cs_n), 32'h2A);
        run_frame(16'h1234, 16'hBEEF, 0, 0, 6'b001000, 0);
        run_frame(16'h4321, 16'h7777, 0, 3, 6'b000010, 0);
        chk(cs_n === 6'b101010, "R12 lines back at mask level", 32'(cs_n), 32'h2A);
        cs_idle_lvl = '1;

        // Random frames
        for (int f = 0; f < 60; f++) begin
            for (int s = 0; s < NA; s++)
                set_attr(s, 3 + int'($urandom % 13), 1'($urandom), 1'($urandom), 1'($urandom));
            tick_div = 1 + int'($urandom % 4);
            run_frame(DW'($urandom), DW'($urandom), 1'($urandom), int'($urandom % NA),
                      CS_W'(1 << ($urandom % CS_W)), (f % 7) == 3);
            repeat ($urandom % 3) @(negedge clk);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule